// File: doc/BRIEF.md
# Condition Flag Update Unit

This block keeps the condition flag byte of an 8-bit accumulator CPU and works out its next value for the logical, rotate and shift, bit-test, carry-manipulation, nibble-rotate and port-input operations. Each cycle the datapath presents an operation code, the result byte, the bit a rotate pushed out, and a bit index. When the operation is valid, the unit merges new flag values into the stored byte. Flags that the operation does not define keep their old values.

The unit has two registered outputs. The first is the flag byte. The second is a per-flag write mask showing which flags the last accepted operation wrote. The flag layout is S at bit 7, Z at bit 6, H at bit 4, P/V at bit 2, N at bit 1 and C at bit 0. Bits 5 and 3 are never written. Arithmetic add and subtract flags and decimal adjust belong to other logic.

Top module: `cfu_top`

## Requirements
- R1: While `rst` is high at a clock edge, `flags_o` and `wmask_o` become 0x00.
- R2: When `op_valid` is low, or `op_code` is 12 to 15 (unused), `flags_o` keeps its value and `wmask_o` becomes 0x00 at the edge.
- R3: op_code 0 (logical AND): H is set to 1, and N and C are cleared. S takes bit 7 of `operand`, Z is 1 when `operand` is zero, and P/V is 1 when `operand` has an even number of ones. The mask is 0xD7.
- R4: op_code 1 (OR) and op_code 2 (XOR): these set S, Z and P/V the same way as R3 and clear H, N and C. The mask is 0xD7.
- R5: op_code 3 (accumulator complement): H and N are set to 1, and all other flags are unchanged. The mask is 0x12.
- R6: op_code 4 (complement carry): H takes the old C, C is inverted, and N is cleared. The mask is 0x13.
- R7: op_code 5 (set carry): C is set to 1, and H and N are cleared. The mask is 0x13.
- R8: op_code 6 (quick accumulator rotate): C takes `shift_bit`, and H and N are cleared. S, Z and P/V are unchanged. The mask is 0x13.
- R9: op_code 7 (general rotate or shift): C takes `shift_bit`, and H and N are cleared. S, Z and P/V are set as in R3. The mask is 0xD7.
- R10: op_code 8 (bit test): Z and P/V are both 1 when `operand[bit_idx]` is 0. H is set to 1 and N is cleared. S and C are unchanged. The mask is 0x56.
- R11: op_code 9 (nibble rotate through memory) and op_code 10 (port input addressed by register): S, Z and P/V are set from `operand` as in R3, and H and N are cleared. C is unchanged. The mask is 0xD6.
- R12: op_code 11 (port input with immediate address) changes no flag, and the mask is 0x00.
- R13: Bits 5 and 3 of `flags_o` never change after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_valid | input | 1 | Operation is applied at this edge |
| op_code | input | 4 | Operation selector (see requirements) |
| operand | input | DATA_W | Result or input byte the flags are taken from |
| shift_bit | input | 1 | Bit pushed out by a rotate or shift |
| bit_idx | input | IDX_W | Bit position examined by the bit test |
| flags_o | output | 8 | Stored flag byte |
| wmask_o | output | 8 | Flags written by the last accepted operation |

## Verification
The stored flag byte is the only state, so any corruption shows on `flags_o` at the edge where it happens. A wrong merge or a wrong mask bit leaves a stale or altered flag that stays visible until a later operation writes that flag. The bench therefore follows a running model across a long chain of operations. A preserved flag that was handled wrongly then surfaces within a few vectors, even when the faulty operation's own written flags look correct. A wrong decode of the write mask is visible on `wmask_o` one edge after the operation.

// File: rtl/cfu_pkg.sv
package cfu_pkg;

  localparam int F_S = 7;
  localparam int F_Z = 6;
  localparam int F_H = 4;
  localparam int F_P = 2;
  localparam int F_N = 1;
  localparam int F_C = 0;

  typedef enum logic [3:0] {
    OP_AND  = 4'd0,
    OP_OR   = 4'd1,
    OP_XOR  = 4'd2,
    OP_CPL  = 4'd3,
    OP_CCF  = 4'd4,
    OP_SCF  = 4'd5,
    OP_ROTA = 4'd6,
    OP_ROTF = 4'd7,
    OP_BIT  = 4'd8,
    OP_NIB  = 4'd9,
    OP_INC  = 4'd10,
    OP_INI  = 4'd11
  } cfu_op_e;

  typedef enum logic [1:0] {
    HS_ZERO = 2'd0,
    HS_ONE  = 2'd1,
    HS_OLDC = 2'd2
  } h_sel_e;

  typedef enum logic [1:0] {
    CS_ZERO  = 2'd0,
    CS_ONE   = 2'd1,
    CS_INV   = 2'd2,
    CS_SHIFT = 2'd3
  } c_sel_e;

  typedef struct packed {
    logic [7:0] mask;
    h_sel_e     h_sel;
    logic       n_val;
    c_sel_e     c_sel;
    logic       z_from_bit;
  } cfu_ctrl_s;

  localparam logic [7:0] M_SZP = 8'(1 << F_S) | 8'(1 << F_Z) | 8'(1 << F_P);
  localparam logic [7:0] M_HN  = 8'(1 << F_H) | 8'(1 << F_N);
  localparam logic [7:0] M_C   = 8'(1 << F_C);

endpackage

// File: rtl/cfu_decode.sv
module cfu_decode
  import cfu_pkg::*;
(
  input  logic [3:0] op_code,
  output cfu_ctrl_s  ctrl
);

  always_comb begin
    ctrl.mask       = 8'h00;
    ctrl.h_sel      = HS_ZERO;
    ctrl.n_val      = 1'b0;
    ctrl.c_sel      = CS_ZERO;
    ctrl.z_from_bit = 1'b0;
    case (op_code)
      OP_AND: begin
        ctrl.mask  = M_SZP | M_HN | M_C;
        ctrl.h_sel = HS_ONE;
      end
      OP_OR, OP_XOR: begin
        ctrl.mask = M_SZP | M_HN | M_C;
      end
      OP_CPL: begin
        ctrl.mask  = M_HN;
        ctrl.h_sel = HS_ONE;
        ctrl.n_val = 1'b1;
      end
      OP_CCF: begin
        ctrl.mask  = M_HN | M_C;
        ctrl.h_sel = HS_OLDC;
        ctrl.c_sel = CS_INV;
      end
      OP_SCF: begin
        ctrl.mask  = M_HN | M_C;
        ctrl.c_sel = CS_ONE;
      end
      OP_ROTA: begin
        ctrl.mask  = M_HN | M_C;
        ctrl.c_sel = CS_SHIFT;
      end
      OP_ROTF: begin
        ctrl.mask  = M_SZP | M_HN | M_C;
        ctrl.c_sel = CS_SHIFT;
      end
      OP_BIT: begin
        ctrl.mask       = 8'(1 << F_Z) | 8'(1 << F_P) | M_HN;
        ctrl.h_sel      = HS_ONE;
        ctrl.z_from_bit = 1'b1;
      end
      OP_NIB, OP_INC: begin
        ctrl.mask = M_SZP | M_HN;
      end
      default: begin
        ctrl.mask = 8'h00;
      end
    endcase
  end

endmodule

// File: rtl/cfu_szp.sv
module cfu_szp #(
  parameter int DATA_W = 8,
  parameter int IDX_W  = 3
) (
  input  logic [DATA_W-1:0] data,
  input  logic [IDX_W-1:0]  idx,
  output logic              sign,
  output logic              zero,
  output logic              par_even,
  output logic              bit_clear
);

  always_comb begin
    sign      = data[DATA_W-1];
    zero      = (data == '0);
    par_even  = ~(^data);
    bit_clear = ~data[idx];
  end

endmodule

// File: rtl/cfu_merge.sv
module cfu_merge
  import cfu_pkg::*;
(
  input  cfu_ctrl_s  ctrl,
  input  logic [7:0] old_flags,
  input  logic       sign,
  input  logic       zero,
  input  logic       par_even,
  input  logic       bit_clear,
  input  logic       shift_bit,
  output logic [7:0] next_flags
);

  logic [7:0] val;

  always_comb begin
    val        = 8'h00;
    val[F_S]   = sign;
    val[F_Z]   = ctrl.z_from_bit ? bit_clear : zero;
    val[F_P]   = ctrl.z_from_bit ? bit_clear : par_even;
    val[F_N]   = ctrl.n_val;
    case (ctrl.h_sel)
      HS_ONE:  val[F_H] = 1'b1;
      HS_OLDC: val[F_H] = old_flags[F_C];
      default: val[F_H] = 1'b0;
    endcase
    case (ctrl.c_sel)
      CS_ONE:   val[F_C] = 1'b1;
      CS_INV:   val[F_C] = ~old_flags[F_C];
      CS_SHIFT: val[F_C] = shift_bit;
      default:  val[F_C] = 1'b0;
    endcase
    next_flags = (old_flags & ~ctrl.mask) | (val & ctrl.mask);
  end

endmodule

// File: rtl/cfu_top.sv
module cfu_top
  import cfu_pkg::*;
#(
  parameter int  DATA_W = 8,
  localparam int IDX_W  = (DATA_W > 1) ? $clog2(DATA_W) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              op_valid,
  input  logic [3:0]        op_code,
  input  logic [DATA_W-1:0] operand,
  input  logic              shift_bit,
  input  logic [IDX_W-1:0]  bit_idx,
  output logic [7:0]        flags_o,
  output logic [7:0]        wmask_o
);

  cfu_ctrl_s  ctrl;
  logic       sign, zero, par_even, bit_clear;
  logic [7:0] next_flags;

  cfu_decode u_dec (
    .op_code (op_code),
    .ctrl    (ctrl)
  );

  cfu_szp #(.DATA_W(DATA_W), .IDX_W(IDX_W)) u_szp (
    .data      (operand),
    .idx       (bit_idx),
    .sign      (sign),
    .zero      (zero),
    .par_even  (par_even),
    .bit_clear (bit_clear)
  );

  cfu_merge u_mrg (
    .ctrl       (ctrl),
    .old_flags  (flags_o),
    .sign       (sign),
    .zero       (zero),
    .par_even   (par_even),
    .bit_clear  (bit_clear),
    .shift_bit  (shift_bit),
    .next_flags (next_flags)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      flags_o <= 8'h00;
      wmask_o <= 8'h00;
    end else if (op_valid) begin
      flags_o <= next_flags;
      wmask_o <= ctrl.mask;
    end else begin
      wmask_o <= 8'h00;
    end
  end

endmodule

// File: rtl/cfu_chk.sv
module cfu_chk
  import cfu_pkg::*;
(
  input logic       clk,
  input logic       rst,
  input logic       op_valid,
  input logic [3:0] op_code,
  input logic [7:0] flags_o,
  input logic [7:0] wmask_o
);

  // R2
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !op_valid |=> ($stable(flags_o) && wmask_o == 8'h00));

  // R13
  spare_bits_chk: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ($stable(flags_o[5]) && $stable(flags_o[3])));

  // R5
  cpl_flags_chk: assert property (@(posedge clk) disable iff (rst)
    (op_valid && op_code == OP_CPL) |=>
      (flags_o[F_H] && flags_o[F_N] && $stable(flags_o[F_C]) &&
       $stable(flags_o[F_S]) && $stable(flags_o[F_Z]) && $stable(flags_o[F_P])));

  // R6
  ccf_swap_chk: assert property (@(posedge clk) disable iff (rst)
    (op_valid && op_code == OP_CCF) |=>
      (flags_o[F_H] == $past(flags_o[F_C]) && flags_o[F_C] != $past(flags_o[F_C]) && !flags_o[F_N]));

  // R7
  scf_set_chk: assert property (@(posedge clk) disable iff (rst)
    (op_valid && op_code == OP_SCF) |=> (flags_o[F_C] && !flags_o[F_H] && !flags_o[F_N]));

  // R12
  in_imm_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (op_valid && op_code == OP_INI) |=> ($stable(flags_o) && wmask_o == 8'h00));

  // R10
  bit_test_chk: assert property (@(posedge clk) disable iff (rst)
    (op_valid && op_code == OP_BIT) |=>
      (flags_o[F_Z] == flags_o[F_P] && flags_o[F_H] && $stable(flags_o[F_C]) && $stable(flags_o[F_S])));

endmodule

bind cfu_top cfu_chk u_chk (
  .clk      (clk),
  .rst      (rst),
  .op_valid (op_valid),
  .op_code  (op_code),
  .flags_o  (flags_o),
  .wmask_o  (wmask_o)
);

// File: tb/sim_cfu_top.sv
module sim_cfu_top;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       op_valid = 1'b0;
  logic [3:0] op_code = 4'd0;
  logic [7:0] operand = 8'h00;
  logic       shift_bit = 1'b0;
  logic [2:0] bit_idx = 3'd0;
  logic [7:0] flags_o, wmask_o;

  int n_vec = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #10 clk = ~clk;

  cfu_top u0 (
    .clk(clk), .rst(rst), .op_valid(op_valid), .op_code(op_code),
    .operand(operand), .shift_bit(shift_bit), .bit_idx(bit_idx),
    .flags_o(flags_o), .wmask_o(wmask_o)
  );

  function automatic string req_of(input int op, input bit v);
    if (!v) return "R2";
    case (op)
      0: return "R3";
      1, 2: return "R4";
      3: return "R5";
      4: return "R6";
      5: return "R7";
      6: return "R8";
      7: return "R9";
      8: return "R10";
      9, 10: return "R11";
      11: return "R12";
      default: return "R2";
    endcase
  endfunction

  function automatic logic [7:0] mask_of(input int op);
    case (op)
      0, 1, 2, 7: return 8'hD7;
      3: return 8'h12;
      4, 5, 6: return 8'h13;
      8: return 8'h56;
      9, 10: return 8'hD6;
      default: return 8'h00;
    endcase
  endfunction

  function automatic logic [7:0] flag_val(input int op, input logic [7:0] d,
                                         input bit sh, input int idx, input logic [7:0] old);
    logic [7:0] v;
    int ones;
    ones = 0;
    for (int k = 0; k < 8; k++) ones += d[k];
    v = 8'h00;
    v[7] = d[7];
    v[6] = (d == 8'h00);
    v[2] = (ones % 2 == 0);
    case (op)
      0: v[4] = 1'b1;
      3: begin v[4] = 1'b1; v[1] = 1'b1; end
      4: begin v[4] = old[0]; v[0] = ~old[0]; end
      5: v[0] = 1'b1;
      6, 7: v[0] = sh;
      8: begin v[4] = 1'b1; v[6] = ~d[idx]; v[2] = ~d[idx]; end
      default: ;
    endcase
    return v;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] model, m, nv;
    int cnt;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    n_vec++;
    // R1: reset state
    if (flags_o !== 8'h00 || wmask_o !== 8'h00) begin
      n_bad++;
      $display("FAIL R1 flags=%h mask=%h exp 00 00", flags_o, wmask_o);
    end
    model = 8'h00;
    cnt = 0;
    for (int op = 0; op < 16; op++) begin
      for (int d = 0; d < 256; d++) begin
        for (int sh = 0; sh < 2; sh++) begin
          bit v;
          int idx;
          v = (cnt % 7) != 3;
          idx = (d + op + sh) % 8;
          op_valid  = v;
          op_code   = 4'(op);
          operand   = 8'(d);
          shift_bit = sh[0];
          bit_idx   = 3'(idx);
          m  = v ? mask_of(op) : 8'h00;
          nv = (model & ~m) | (flag_val(op, 8'(d), sh[0], idx, model) & m);
          @(negedge clk);
          n_vec++;
          if (flags_o !== nv || wmask_o !== m) begin
            n_bad++;
            $display("FAIL %s op=%0d d=%h flags=%h mask=%h exp %h %h",
                     req_of(op, v), op, d, flags_o, wmask_o, nv, m);
          end
          // R13: bits 5 and 3 stay clear
          if (flags_o[5] !== 1'b0 || flags_o[3] !== 1'b0) begin
            n_bad++;
            $display("FAIL R13 flags=%h exp bits5/3 = 0", flags_o);
          end
          model = nv;
          cnt++;
        end
      end
    end
    op_valid = 1'b0;
    rst = 1'b1;
    @(negedge clk);
    n_vec++;
    if (flags_o !== 8'h00 || wmask_o !== 8'h00) begin
      n_bad++;
      $display("FAIL R1 flags=%h mask=%h exp 00 00", flags_o, wmask_o);
    end
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule